// File: doc/BRIEF.md
# I2C Slave Word-Register Interface

This block is a bus slave for a two-wire serial interface. It answers only to the 7-bit address 0x36 and gives a bus master read and write access to a small bank of 16-bit registers. The clock and data lines arrive from the pads. Each line passes through a synchronizer, and the block then finds clock edges and the START and STOP conditions on the synchronized copies. It never drives the data line high. Its single output toward the pad is a pull-low enable, and an external resistor supplies the high level.

A write transaction works as follows. The first byte after the address sets a byte pointer, and each later byte is stored at that pointer, which then steps forward. A read transaction returns bytes starting at the current pointer. The usual way to read a chosen register is to write only the pointer, issue a Repeated START, and then read. Each register appears as two bytes: its upper half sits at an even byte address and its lower half at the following odd one. The register contents are also presented in parallel to the surrounding logic.

Top module: `i2c_reg_slave`

## Requirements
- R1: An address byte of 0x6C (write) or 0x6D (read) is acknowledged: `sda_pull_o` holds SDA low during the ninth clock pulse.
- R2: For any other 7-bit address the block does not acknowledge. It keeps SDA released for the rest of that transaction, so read bits come back as 1, and the following bytes change no register.
- R3: A START recognised in any state, including a Repeated START in the middle of a transaction, restarts address reception with a cleared bit count and needs no STOP first.
- R4: A STOP returns the block to idle with SDA released.
- R5: In a write, the first data byte loads the byte pointer from its low log2(2·NUM_WORDS) bits. Each later byte is written at the pointer, and the pointer then increments, wrapping from the last byte to byte 0. The block acknowledges every data byte.
- R6: Register k holds byte address 2k in bits [15:8] and byte address 2k+1 in bits [7:0]. It is presented on `regs_o[16k+15:16k]`.
- R7: In a read, the block drives the byte at the pointer, most significant bit first, and increments the pointer after each byte. A master ACK continues the read. A master NAK ends it and leaves SDA released.
- R8: `sda_pull_o` changes only while SCL is low.
- R9: After reset every register is 0, the pointer is 0, and SDA is released.
- R10: The pointer keeps its value from one transaction to the next, so a read that follows a pointer write and a Repeated START begins at that pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x faster than SCL |
| rst_n | input | 1 | Active-low reset |
| scl_i | input | 1 | SCL level from the pad (asynchronous) |
| sda_i | input | 1 | SDA level from the pad (asynchronous) |
| sda_pull_o | output | 1 | Pad enable that pulls SDA low when 1 |
| regs_o | output | 16*NUM_WORDS | Register contents, register k at bits [16k+15:16k] |

## Verification
The hardest situation to reach is a Repeated START that takes the block straight from one transaction into another. The block must drop its current bit position and direction, yet keep the pointer. The bench reaches it in two ways. It writes only a pointer and then sends a Repeated START into a read, in random combinations with multi-byte reads. It also sends an address the block does not own and follows it at once with a Repeated START and the block's own write address. Pointer wrap is driven by choosing pointers near the top of the byte space and writing bursts across it.

// File: rtl/i2c_rs_pkg.sv
package i2c_rs_pkg;

    // Own 7-bit bus address.
    localparam logic [6:0] OWN_ADDR = 7'h36;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ADDR  = 3'd1,
        ST_WDATA = 3'd2,
        ST_ACK   = 3'd3,
        ST_RD    = 3'd4,
        ST_RACK  = 3'd5
    } slv_state_e;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_o,
    output logic sda_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);

    logic [STAGES-1:0] scl_q, scl_d;
    logic [STAGES-1:0] sda_q, sda_d;
    logic              scl_prev_q, scl_prev_d;
    logic              sda_prev_q, sda_prev_d;

    always_comb begin
        scl_d      = {scl_q[STAGES-2:0], scl_i};
        sda_d      = {sda_q[STAGES-2:0], sda_i};
        scl_prev_d = scl_q[STAGES-1];
        sda_prev_d = sda_q[STAGES-1];
    end

    // Idle bus level is high on both lines.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q      <= '1;
            sda_q      <= '1;
            scl_prev_q <= 1'b1;
            sda_prev_q <= 1'b1;
        end else begin
            scl_q      <= scl_d;
            sda_q      <= sda_d;
            scl_prev_q <= scl_prev_d;
            sda_prev_q <= sda_prev_d;
        end
    end

    assign scl_o      = scl_q[STAGES-1];
    assign sda_o      = sda_q[STAGES-1];
    assign scl_rise_o = scl_o & ~scl_prev_q;
    assign scl_fall_o = ~scl_o & scl_prev_q;
    assign start_o    = scl_o & scl_prev_q & sda_prev_q & ~sda_o;
    assign stop_o     = scl_o & scl_prev_q & ~sda_prev_q & sda_o;

endmodule

// File: rtl/i2c_word_bank.sv
module i2c_word_bank #(
    parameter int NUM_WORDS = 4,
    parameter int BAW       = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [BAW-1:0]          wr_addr,
    input  logic [7:0]              wr_data,
    input  logic [BAW-1:0]          rd_addr,
    output logic [7:0]              rd_data,
    output logic [NUM_WORDS*16-1:0] words_o
);

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        logic [15:0] word_q, word_d;
        logic        hit;

        assign hit = wr_en && ((int'(wr_addr) / 2) == w);

        // Even byte address -> upper half, odd -> lower half.
        always_comb begin
            word_d = word_q;
            if (hit) begin
                if (wr_addr[0]) word_d[7:0]  = wr_data;
                else            word_d[15:8] = wr_data;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) word_q <= '0;
            else        word_q <= word_d;
        end

        assign words_o[16*w +: 16] = word_q;
    end

    always_comb begin
        if (rd_addr[0]) rd_data = words_o[16*(int'(rd_addr) / 2) +: 8];
        else            rd_data = words_o[16*(int'(rd_addr) / 2) + 8 +: 8];
    end

    // R6: an even byte address lands in the upper half of its word
    a_r6_even_is_high: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_addr[0]) |=>
        (words_o[16*(int'($past(wr_addr)) / 2) + 8 +: 8] == $past(wr_data)));

    // R6: an odd byte address lands in the lower half of its word
    a_r6_odd_is_low: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr[0]) |=>
        (words_o[16*(int'($past(wr_addr)) / 2) +: 8] == $past(wr_data)));

endmodule

// File: rtl/i2c_reg_slave.sv
module i2c_reg_slave
    import i2c_rs_pkg::*;
#(
    parameter int NUM_WORDS   = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    scl_i,
    input  logic                    sda_i,
    output logic                    sda_pull_o,
    output logic [NUM_WORDS*16-1:0] regs_o
);

    localparam int NBYTES = 2 * NUM_WORDS;
    localparam int BAW    = $clog2(NBYTES);

    typedef struct packed {
        slv_state_e     st;
        logic [3:0]     cnt;
        logic [7:0]     sh;
        logic [7:0]     tx;
        logic [BAW-1:0] ptr;
        logic           first;
        logic           rw;
        logic           mack;
        logic           pull;
    } ctl_t;

    ctl_t q, d;

    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic wr_en;
    logic [7:0] rd_byte;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .scl_o      (scl_s),
        .sda_o      (sda_s),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_det),
        .stop_o     (stop_det)
    );

    i2c_word_bank #(.NUM_WORDS(NUM_WORDS), .BAW(BAW)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (q.ptr),
        .wr_data (q.sh),
        .rd_addr (q.ptr),
        .rd_data (rd_byte),
        .words_o (regs_o)
    );

    always_comb begin
        d     = q;
        wr_en = 1'b0;
        unique case (q.st)
            ST_IDLE: ;
            ST_ADDR: begin
                if (scl_rise && q.cnt < 4'd8) begin
                    d.sh  = {q.sh[6:0], sda_s};
                    d.cnt = q.cnt + 4'd1;
                end else if (scl_fall && q.cnt == 4'd8) begin
                    if (q.sh[7:1] == OWN_ADDR) begin
                        d.rw    = q.sh[0];
                        d.first = 1'b1;
                        d.st    = ST_ACK;
                    end else begin
                        d.st = ST_IDLE;
                    end
                end
            end
            ST_WDATA: begin
                if (scl_rise && q.cnt < 4'd8) begin
                    d.sh  = {q.sh[6:0], sda_s};
                    d.cnt = q.cnt + 4'd1;
                end else if (scl_fall && q.cnt == 4'd8) begin
                    if (q.first) begin
                        d.ptr   = q.sh[BAW-1:0];
                        d.first = 1'b0;
                    end else begin
                        wr_en = 1'b1;
                        d.ptr = q.ptr + 1'b1;
                    end
                    d.st = ST_ACK;
                end
            end
            ST_ACK: begin
                if (scl_fall) begin
                    d.cnt = '0;
                    if (q.rw) begin
                        d.st = ST_RD;
                        d.tx = rd_byte;
                    end else begin
                        d.st = ST_WDATA;
                    end
                end
            end
            ST_RD: begin
                if (scl_fall) begin
                    if (q.cnt == 4'd7) begin
                        d.st  = ST_RACK;
                        d.cnt = '0;
                        d.ptr = q.ptr + 1'b1;
                    end else begin
                        d.tx  = {q.tx[6:0], 1'b1};
                        d.cnt = q.cnt + 4'd1;
                    end
                end
            end
            ST_RACK: begin
                if (scl_rise) begin
                    d.mack = ~sda_s;
                end else if (scl_fall) begin
                    if (q.mack) begin
                        d.st  = ST_RD;
                        d.tx  = rd_byte;
                        d.cnt = '0;
                    end else begin
                        d.st = ST_IDLE;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase

        if (start_det) begin
            d.st  = ST_ADDR;
            d.cnt = '0;
            d.sh  = '0;
        end else if (stop_det) begin
            d.st = ST_IDLE;
        end

        d.pull = (d.st == ST_ACK) || (d.st == ST_RD && !d.tx[7]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sda_pull_o = q.pull;

    // R3: a START always restarts address reception from bit 0
    a_r3_start_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (q.st == ST_ADDR && q.cnt == 4'd0));

    // R4: a STOP leaves the block idle with SDA released
    a_r4_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (q.st == ST_IDLE && !sda_pull_o));

    // R2: nothing is driven while idle
    a_r2_idle_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_IDLE) |-> !sda_pull_o);

    // R1: the address acknowledge only follows our own address
    a_r1_ack_own_only: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sda_pull_o) && $past(q.st == ST_ADDR)) |->
        ($past(q.sh[7:1]) == OWN_ADDR));

    // R8: the pull enable moves only while SCL is low
    a_r8_pull_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_pull_o != $past(sda_pull_o)) |->
        (!scl_s || $past(start_det) || $past(stop_det)));

    // R5: the bit counter never passes the byte length
    a_r5_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= 4'd8);

endmodule

// File: tb/i2c_reg_slave_bench.sv
module i2c_reg_slave_bench;

    localparam int NW = 4;
    localparam int NB = 2 * NW;
    localparam int Q  = 6;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic            rst_n;
    logic            m_scl, m_sda;
    logic            sda_pull;
    logic [NW*16-1:0] regs;
    wire             sda_bus = m_sda & ~sda_pull;

    i2c_reg_slave #(.NUM_WORDS(NW), .SYNC_STAGES(2)) u_i2c_reg_slave (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (m_scl),
        .sda_i      (sda_bus),
        .sda_pull_o (sda_pull),
        .regs_o     (regs)
    );

    int          checks = 0;
    int          errors = 0;
    int          viol   = 0;
    logic [7:0]  mem [NB];
    int          ptr;
    logic [7:0]  buf_b [16];

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // R8 monitor: pull enable must not move while SCL stays high
    logic prev_pull = 1'b0, prev_scl = 1'b1;
    always @(posedge clk) begin
        #2;
        if (rst_n === 1'b1 && sda_pull !== prev_pull && m_scl && prev_scl) viol++;
        prev_pull = sda_pull;
        prev_scl  = m_scl;
    end

    task automatic q_wait;
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start;
        m_sda = 1'b1; q_wait;
        m_scl = 1'b1; q_wait;
        m_sda = 1'b0; q_wait;
        m_scl = 1'b0; q_wait;
    endtask

    task automatic bus_stop;
        m_sda = 1'b0; q_wait;
        m_scl = 1'b1; q_wait;
        m_sda = 1'b1; q_wait;
    endtask

    task automatic put_bit(input logic b);
        m_sda = b;    q_wait;
        m_scl = 1'b1; q_wait; q_wait;
        m_scl = 1'b0; q_wait;
    endtask

    task automatic get_bit(output logic b);
        m_sda = 1'b1; q_wait;
        m_scl = 1'b1; q_wait;
        b = sda_bus;  q_wait;
        m_scl = 1'b0; q_wait;
    endtask

    task automatic put_byte(input logic [7:0] v, output bit acked);
        logic b;
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(b);
        acked = !b;
    endtask

    task automatic get_byte(output logic [7:0] v, input bit give_ack);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            v[i] = b;
        end
        put_bit(!give_ack);
    endtask

    function automatic logic [15:0] exp_word(input int k);
        return {mem[2*k], mem[2*k+1]};
    endfunction

    task automatic check_regs(input string req);
        for (int k = 0; k < NW; k++)
            chk(regs[16*k +: 16] == exp_word(k), req, regs[16*k +: 16], exp_word(k));
    endtask

    task automatic wr_txn(input logic [7:0] p, input int n);
        bit a;
        bus_start;
        put_byte(8'h6C, a); chk(a, "R1 write address ack", a, 1);
        put_byte(p, a);     chk(a, "R5 pointer byte ack", a, 1);
        ptr = int'(p) % NB;
        for (int i = 0; i < n; i++) begin
            put_byte(buf_b[i], a);
            chk(a, "R5 data byte ack", a, 1);
            mem[ptr] = buf_b[i];
            ptr = (ptr + 1) % NB;
        end
        bus_stop;
        q_wait;
        chk(sda_pull == 1'b0, "R4 released after stop", sda_pull, 0);
        check_regs("R6 word contents after write");
    endtask

    task automatic rd_txn(input logic [7:0] p, input int n, input bit set_ptr);
        bit a;
        logic [7:0] v;
        if (set_ptr) begin
            bus_start;
            put_byte(8'h6C, a); chk(a, "R1 write address ack", a, 1);
            put_byte(p, a);     chk(a, "R5 pointer byte ack", a, 1);
            ptr = int'(p) % NB;
        end
        bus_start;  // Repeated START when set_ptr (R3, R10)
        put_byte(8'h6D, a); chk(a, "R1 read address ack", a, 1);
        for (int i = 0; i < n; i++) begin
            get_byte(v, i < n - 1);
            chk(v == mem[ptr], "R7 R10 read byte", v, mem[ptr]);
            ptr = (ptr + 1) % NB;
        end
        chk(sda_pull == 1'b0, "R7 released after NAK", sda_pull, 0);
        bus_stop;
    endtask

    task automatic wrong_txn(input logic [7:0] addr, input int n);
        bit a;
        logic [7:0] v;
        bus_start;
        put_byte(addr, a); chk(!a, "R2 foreign address not acked", a, 0);
        for (int i = 0; i < n; i++) begin
            if (addr[0]) begin
                get_byte(v, 1'b1);
                chk(v == 8'hFF, "R2 bus released on foreign read", v, 8'hFF);
            end else begin
                put_byte(8'($urandom), a);
                chk(!a, "R2 foreign data not acked", a, 0);
            end
        end
        bus_stop;
        check_regs("R2 registers untouched");
    endtask

    task automatic report;
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog (all requirements) actual=running expected=finished");
        report;
        $finish;
    end

    initial begin
        bit a;
        logic [7:0] v;
        int seed_v;
        seed_v = int'($urandom(32'd24681357));
        for (int i = 0; i < NB; i++) mem[i] = 8'h00;
        ptr   = 0;
        rst_n = 1'b0;
        m_scl = 1'b1;
        m_sda = 1'b1;
        repeat (10) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R9: reset state
        chk(regs == '0, "R9 registers zero after reset", regs, 0);
        chk(sda_pull == 1'b0, "R9 SDA released after reset", sda_pull, 0);
        // R9: pointer starts at 0, read without setting it
        rd_txn(8'h00, 2, 1'b0);

        // R5: pointer taken from low bits (0x0A -> byte 2)
        buf_b[0] = 8'hA5; buf_b[1] = 8'h5A;
        wr_txn(8'h0A, 2);
        chk(regs[31:16] == 16'hA55A, "R6 big-endian word 1", regs[31:16], 16'hA55A);

        // R5: wrap from last byte to byte 0
        buf_b[0] = 8'h3C; buf_b[1] = 8'hC3; buf_b[2] = 8'h11;
        wr_txn(8'h07, 3);
        chk(regs[63:48] == {mem[6], 8'h3C}, "R5 wrap last byte", regs[63:48], {mem[6], 8'h3C});
        chk(regs[15:0] == 16'hC311, "R5 wrap to byte 0", regs[15:0], 16'hC311);

        // R2: foreign write and read addresses
        wrong_txn(8'h6E, 2);
        wrong_txn(8'h6F, 1);
        wrong_txn(8'hEC, 1);

        // R3: foreign address, then Repeated START into own write
        bus_start;
        put_byte(8'h70, a); chk(!a, "R2 foreign before Sr", a, 0);
        bus_start;
        put_byte(8'h6C, a); chk(a, "R3 Sr restarts address", a, 1);
        put_byte(8'h04, a); chk(a, "R3 pointer after Sr", a, 1);
        put_byte(8'h96, a); chk(a, "R3 data after Sr", a, 1);
        bus_stop;
        mem[4] = 8'h96;
        check_regs("R3 write after Sr");

        // R10: pointer write, Sr, read across wrap
        rd_txn(8'h06, 4, 1'b1);
        // R10: pointer held across a STOP
        bus_start;
        put_byte(8'h6C, a);
        put_byte(8'h03, a);
        bus_stop;
        ptr = 3;
        rd_txn(8'h00, 2, 1'b0);

        // R3: Repeated START in the middle of a read
        bus_start;
        put_byte(8'h6D, a);
        get_byte(v, 1'b1);
        chk(v == mem[ptr], "R7 first byte before Sr", v, mem[ptr]);
        ptr = (ptr + 1) % NB;
        get_byte(v, 1'b0);
        ptr = (ptr + 1) % NB;
        bus_start;
        put_byte(8'h6C, a); chk(a, "R3 Sr after read", a, 1);
        bus_stop;

        // Random mix
        for (int t = 0; t < 30; t++) begin
            int kind;
            int n;
            logic [7:0] p;
            kind = int'($urandom_range(0, 9));
            n    = int'($urandom_range(1, 5));
            p    = 8'($urandom);
            if (kind < 5) begin
                for (int i = 0; i < n; i++) buf_b[i] = 8'($urandom);
                wr_txn(p, n);
            end else if (kind < 9) begin
                rd_txn(p, n, 1'b1);
            end else begin
                wrong_txn({7'($urandom_range(0, 53)), 1'b0}, 1);
            end
        end

        chk(viol == 0, "R8 pull moves only with SCL low", viol, 0);
        report;
        $finish;
    end

endmodule